// File: doc/BRIEF.md
# Turbo Frame Block Segmenter

This block prepares a frame for a turbo encoder. At the start of a frame it takes the payload length in bits. It rounds that length up to a whole number of 512-bit units and splits the result into codewords of 2048 and 512 information bits. Each codeword is encoded on its own. The short codewords always number between one and four, and they sit at the end of the frame, after every long codeword.

For every codeword, in transmission order, the block issues a descriptor over a valid/ready handshake. A descriptor carries:
- the codeword size;
- how many of its bits are padding;
- a flag marking the final codeword;
- a flag marking a short tail codeword.

At the same time the block passes the payload bits from an input stream to an output stream, one bit per transfer. After the payload it appends the zero pad bits, so that the encoder receives exactly the padded frame. A zero-length payload is refused: the block raises an error pulse and starts no frame.

Top module: `turboSegmenter`

## Requirements
- R1: After reset, lenReady is 1 and descValid, bitOutValid and lenError are 0.
- R2: With K = ceil(length/512), the frame holds ((K-1) mod 4)+1 descriptors with descBlockBits = 512.
- R3: The frame holds (K - short count)/4 descriptors with descBlockBits = 2048, and all of them come before every 512-bit descriptor.
- R4: descTail is 1 exactly on 512-bit descriptors. descLast is 1 only on the final descriptor of a frame, and no descriptor follows it in that frame.
- R5: descPadBits equals K*512 - length on the final descriptor and 0 on every other descriptor.
- R6: The output bit stream carries exactly K*512 bits. The first `length` bits equal the input bits in order, and the remaining bits are 0.
- R7: A length of 0 offered while lenReady is 1 makes lenError 1 for the following cycle. It produces no descriptor and no output bit, and lenReady stays 1.
- R8: lenReady falls on the cycle after a nonzero length is accepted. It returns only after every descriptor and every bit of the frame has been transferred. Lengths offered while lenReady is 0 are ignored.
- R9: While descValid is 1 and descReady is 0, the descriptor stays valid and all of its fields hold their values.
- R10: bitInReady is 0 while pad bits are being emitted, so no input bit is consumed during padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lenValid | input | 1 | Payload length offered |
| lenBits | input | 16 | Payload length in bits |
| lenReady | output | 1 | Block idle; the length is taken when lenValid is 1 |
| lenError | output | 1 | One-cycle pulse after a refused zero length |
| descValid | output | 1 | Descriptor available |
| descReady | input | 1 | Descriptor consumer ready |
| descBlockBits | output | 12 | Codeword size in information bits (2048 or 512) |
| descPadBits | output | 9 | Number of pad bits in this codeword |
| descLast | output | 1 | Final codeword of the frame |
| descTail | output | 1 | Short tail codeword |
| bitInValid | input | 1 | Payload bit available |
| bitInData | input | 1 | Payload bit |
| bitInReady | output | 1 | Payload bit taken this cycle |
| bitOutValid | output | 1 | Output bit available |
| bitOutData | output | 1 | Payload or pad bit |
| bitOutReady | input | 1 | Output bit consumer ready |

## Verification
The descriptor stream and the bit stream advance independently, so the final descriptor handshake and the final pad-bit handshake can land on the same clock edge. Both of them gate the frame's completion. The bench provokes this with a single-codeword frame and a descriptor consumer that stays stalled until only one bit remains to be delivered. It then judges that both transfers are scored once, that lenReady comes back, and that the next frame is segmented correctly.

// File: rtl/turboSegPkg.sv
`timescale 1ns/1ps
package turboSegPkg;
  typedef struct packed {
    logic loadFrame;
    logic runFrame;
  } segStrobes_t;
endpackage

// File: rtl/segCtrl.sv
`timescale 1ns/1ps
module segCtrl
  import turboSegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lenValid,
  input  logic        lenNonZero,
  input  logic        descDone,
  input  logic        bitsDone,
  output logic        lenReady,
  output logic        lenError,
  output segStrobes_t strobes
);
  typedef enum logic {SEG_IDLE, SEG_RUN} segState_t;
  segState_t state;

  always_comb begin
    lenReady          = (state == SEG_IDLE);
    strobes.loadFrame = lenReady && lenValid && lenNonZero;
    strobes.runFrame  = (state == SEG_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEG_IDLE;
      lenError <= 1'b0;
    end else begin
      lenError <= lenReady && lenValid && !lenNonZero;
      case (state)
        SEG_IDLE: if (strobes.loadFrame) state <= SEG_RUN;
        SEG_RUN:  if (descDone && bitsDone) state <= SEG_IDLE;
        default:  state <= SEG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/segDatapath.sv
`timescale 1ns/1ps
module segDatapath
  import turboSegPkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int SMALL_BITS    = 512,
  parameter int BIG_PER_SMALL = 4,
  localparam int SMALL_LOG    = $clog2(SMALL_BITS),
  localparam int BIG_BITS     = SMALL_BITS * BIG_PER_SMALL,
  localparam int SIZE_W       = $clog2(BIG_BITS + 1),
  localparam int PAD_W        = SMALL_LOG
)(
  input  logic              clk,
  input  logic              rstN,
  input  segStrobes_t       strobes,
  input  logic [LEN_W-1:0]  lenBits,
  input  logic              descReady,
  input  logic              bitInValid,
  input  logic              bitInData,
  input  logic              bitOutReady,
  output logic              descValid,
  output logic [SIZE_W-1:0] descBlockBits,
  output logic [PAD_W-1:0]  descPadBits,
  output logic              descLast,
  output logic              descTail,
  output logic              bitInReady,
  output logic              bitOutValid,
  output logic              bitOutData,
  output logic              descDone,
  output logic              bitsDone
);
  localparam int CNT_W       = LEN_W + 1;
  localparam int SMALL_CNT_W = $clog2(BIG_PER_SMALL + 1);

  logic [CNT_W-1:0]       unitsNew, unitsLess, totalNew, bigNew;
  logic [SMALL_CNT_W-1:0] smallNew;
  logic [PAD_W-1:0]       padNew;

  logic [LEN_W-1:0]       payLen;
  logic [CNT_W-1:0]       totalBits, bitIdx, bigLeft;
  logic [SMALL_CNT_W-1:0] smallLeft;
  logic [PAD_W-1:0]       padReg;
  logic                   inPayload, bitsActive, descFire, bitFire;

  // Frame plan, evaluated on the length presented at load time
  always_comb begin
    unitsNew  = (CNT_W'(lenBits) + CNT_W'(SMALL_BITS - 1)) >> SMALL_LOG;
    unitsLess = unitsNew - CNT_W'(1);
    totalNew  = unitsNew << SMALL_LOG;
    padNew    = PAD_W'(totalNew - CNT_W'(lenBits));
  end

  generate
    if ((BIG_PER_SMALL & (BIG_PER_SMALL - 1)) == 0) begin : g_pow2Split
      localparam int BIG_LOG = $clog2(BIG_PER_SMALL);
      always_comb begin
        smallNew = SMALL_CNT_W'(unitsLess & CNT_W'(BIG_PER_SMALL - 1)) + SMALL_CNT_W'(1);
        bigNew   = (unitsNew - CNT_W'(smallNew)) >> BIG_LOG;
      end
    end else begin : g_divSplit
      always_comb begin
        smallNew = SMALL_CNT_W'(unitsLess % CNT_W'(BIG_PER_SMALL)) + SMALL_CNT_W'(1);
        bigNew   = (unitsNew - CNT_W'(smallNew)) / CNT_W'(BIG_PER_SMALL);
      end
    end
  endgenerate

  // Descriptor view of the remaining plan
  always_comb begin
    descDone      = (bigLeft == '0) && (smallLeft == '0);
    descValid     = strobes.runFrame && !descDone;
    descTail      = (bigLeft == '0);
    descBlockBits = descTail ? SIZE_W'(SMALL_BITS) : SIZE_W'(BIG_BITS);
    descLast      = descTail && (smallLeft == SMALL_CNT_W'(1));
    descPadBits   = descLast ? padReg : '0;
    descFire      = descValid && descReady;
  end

  // Bit stream: payload pass-through, then zero padding
  always_comb begin
    bitsDone    = (bitIdx == totalBits);
    bitsActive  = strobes.runFrame && !bitsDone;
    inPayload   = bitIdx < CNT_W'(payLen);
    bitOutValid = bitsActive && (inPayload ? bitInValid : 1'b1);
    bitOutData  = inPayload ? bitInData : 1'b0;
    bitInReady  = bitsActive && inPayload && bitOutReady;
    bitFire     = bitOutValid && bitOutReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payLen    <= '0;
      totalBits <= '0;
      bitIdx    <= '0;
      bigLeft   <= '0;
      smallLeft <= '0;
      padReg    <= '0;
    end else if (strobes.loadFrame) begin
      payLen    <= lenBits;
      totalBits <= totalNew;
      bitIdx    <= '0;
      bigLeft   <= bigNew;
      smallLeft <= smallNew;
      padReg    <= padNew;
    end else begin
      if (descFire) begin
        if (bigLeft != '0) bigLeft <= bigLeft - CNT_W'(1);
        else               smallLeft <= smallLeft - SMALL_CNT_W'(1);
      end
      if (bitFire) bitIdx <= bitIdx + CNT_W'(1);
    end
  end
endmodule

// File: rtl/turboSegmenter.sv
`timescale 1ns/1ps
module turboSegmenter
  import turboSegPkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int SMALL_BITS    = 512,
  parameter int BIG_PER_SMALL = 4,
  localparam int SMALL_LOG    = $clog2(SMALL_BITS),
  localparam int BIG_BITS     = SMALL_BITS * BIG_PER_SMALL,
  localparam int SIZE_W       = $clog2(BIG_BITS + 1),
  localparam int PAD_W        = SMALL_LOG
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lenValid,
  input  logic [LEN_W-1:0]  lenBits,
  output logic              lenReady,
  output logic              lenError,
  output logic              descValid,
  input  logic              descReady,
  output logic [SIZE_W-1:0] descBlockBits,
  output logic [PAD_W-1:0]  descPadBits,
  output logic              descLast,
  output logic              descTail,
  input  logic              bitInValid,
  input  logic              bitInData,
  output logic              bitInReady,
  output logic              bitOutValid,
  output logic              bitOutData,
  input  logic              bitOutReady
);
  segStrobes_t strobes;
  logic        descDone, bitsDone;

  segCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .lenValid   (lenValid),
    .lenNonZero (|lenBits),
    .descDone   (descDone),
    .bitsDone   (bitsDone),
    .lenReady   (lenReady),
    .lenError   (lenError),
    .strobes    (strobes)
  );

  segDatapath #(
    .LEN_W         (LEN_W),
    .SMALL_BITS    (SMALL_BITS),
    .BIG_PER_SMALL (BIG_PER_SMALL)
  ) data_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .lenBits       (lenBits),
    .descReady     (descReady),
    .bitInValid    (bitInValid),
    .bitInData     (bitInData),
    .bitOutReady   (bitOutReady),
    .descValid     (descValid),
    .descBlockBits (descBlockBits),
    .descPadBits   (descPadBits),
    .descLast      (descLast),
    .descTail      (descTail),
    .bitInReady    (bitInReady),
    .bitOutValid   (bitOutValid),
    .bitOutData    (bitOutData),
    .descDone      (descDone),
    .bitsDone      (bitsDone)
  );
endmodule

// File: rtl/segChecker.sv
`timescale 1ns/1ps
module segChecker #(
  parameter int SIZE_W = 12,
  parameter int PAD_W  = 9
)(
  input logic              clk,
  input logic              rstN,
  input logic              lenReady,
  input logic              lenError,
  input logic              descValid,
  input logic              descReady,
  input logic [SIZE_W-1:0] descBlockBits,
  input logic [PAD_W-1:0]  descPadBits,
  input logic              descLast,
  input logic              descTail,
  input logic              bitInReady,
  input logic              bitOutValid,
  input logic              bitOutReady,
  input logic              bitOutData
);
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    lenReady |-> !descValid && !bitOutValid); // R8

  AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(descBlockBits) && $stable(descPadBits)
      && $stable(descLast) && $stable(descTail)); // R9

  AST_BIG_BEFORE_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descReady && descTail |=> !descValid || descTail); // R3

  AST_LAST_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descReady && descLast |=> !descValid); // R4

  AST_PAD_ON_LAST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descLast |-> descPadBits == '0); // R5

  AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    bitOutValid && bitOutReady && !bitInReady |-> !bitOutData); // R6

  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    lenError |-> lenReady && !descValid && !bitOutValid); // R7
endmodule

bind turboSegmenter segChecker #(
  .SIZE_W (SIZE_W),
  .PAD_W  (PAD_W)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .lenReady      (lenReady),
  .lenError      (lenError),
  .descValid     (descValid),
  .descReady     (descReady),
  .descBlockBits (descBlockBits),
  .descPadBits   (descPadBits),
  .descLast      (descLast),
  .descTail      (descTail),
  .bitInReady    (bitInReady),
  .bitOutValid   (bitOutValid),
  .bitOutReady   (bitOutReady),
  .bitOutData    (bitOutData)
);

// File: tb/turboSegmenter_tb_top.sv
`timescale 1ns/1ps
module turboSegmenter_tb_top;
  localparam int LEN_W  = 16;
  localparam int SIZE_W = 12;
  localparam int PAD_W  = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lenValid = 1'b0;
  logic [LEN_W-1:0] lenBits = '0;
  logic lenReady, lenError, descValid, descLast, descTail;
  logic descReady = 1'b0;
  logic [SIZE_W-1:0] descBlockBits;
  logic [PAD_W-1:0] descPadBits;
  logic bitInValid = 1'b0, bitInData = 1'b0, bitOutReady = 1'b0;
  logic bitInReady, bitOutValid, bitOutData;

  always #2.5 clk = ~clk;

  turboSegmenter dut_i (
    .clk(clk), .rstN(rstN), .lenValid(lenValid), .lenBits(lenBits),
    .lenReady(lenReady), .lenError(lenError), .descValid(descValid),
    .descReady(descReady), .descBlockBits(descBlockBits), .descPadBits(descPadBits),
    .descLast(descLast), .descTail(descTail), .bitInValid(bitInValid),
    .bitInData(bitInData), .bitInReady(bitInReady), .bitOutValid(bitOutValid),
    .bitOutData(bitOutData), .bitOutReady(bitOutReady)
  );

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic [PAD_W-1:0]  pad;
    logic              last;
    logic              tail;
  } expDesc_t;

  expDesc_t descQ[$];
  logic     bitQ[$];
  logic     padQ[$];
  logic     srcQ[$];
  int descMode = 0, bitMode = 0, srcMode = 0;
  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sampleWait();
    @(negedge clk);
    #1.5;
  endtask

  // Payload source
  initial begin
    forever begin
      @(negedge clk);
      bitInValid = (srcQ.size() > 0) && (srcMode == 0 || ($urandom % 4) != 0);
      bitInData  = (srcQ.size() > 0) ? srcQ[0] : 1'b0;
      #1.5;
      if (bitInValid && bitInReady) void'(srcQ.pop_front());
    end
  end

  // Bit monitor
  initial begin
    forever begin
      logic e, p;
      @(negedge clk);
      bitOutReady = (bitMode == 0) ? 1'b1 : (($urandom % 3) != 0);
      #1.5;
      if (bitOutValid && bitOutReady) begin
        if (bitQ.size() == 0) begin
          check(1'b0, "R6", "unexpected output bit", 1, 0);
        end else begin
          e = bitQ.pop_front();
          p = padQ.pop_front();
          check(bitOutData == e, "R6", "output bit value", bitOutData, e);
          if (p) check(!bitInReady, "R10", "input taken during pad", bitInReady, 0);
        end
      end
    end
  end

  // Descriptor monitor
  initial begin
    expDesc_t cur, prevD, e;
    bit held = 1'b0;
    prevD = '0;
    forever begin
      @(negedge clk);
      case (descMode)
        0:       descReady = 1'b1;
        1:       descReady = (($urandom % 3) == 0);
        default: descReady = (bitQ.size() <= 1);
      endcase
      #1.5;
      cur = '{size: descBlockBits, pad: descPadBits, last: descLast, tail: descTail};
      if (held) check(descValid && cur == prevD, "R9", "stalled descriptor changed",
                      longint'(cur), longint'(prevD));
      held  = descValid && !descReady;
      prevD = cur;
      if (descValid && descReady) begin
        if (descQ.size() == 0) begin
          check(1'b0, "R4", "descriptor beyond frame end", longint'(cur), 0);
        end else begin
          e = descQ.pop_front();
          check(cur == e, "R2 R3 R4 R5", "descriptor fields", longint'(cur), longint'(e));
        end
      end
    end
  end

  task automatic runFrame(input int len, input int dm, input int bm, input int sm);
    int k, ns, nb, pad;
    descMode = dm; bitMode = bm; srcMode = sm;
    k   = (len + 511) / 512;
    ns  = ((k - 1) % 4) + 1;
    nb  = (k - ns) / 4;
    pad = k * 512 - len;
    for (int i = 0; i < nb; i++)
      descQ.push_back('{size: SIZE_W'(2048), pad: '0, last: 1'b0, tail: 1'b0});
    for (int i = 0; i < ns; i++)
      descQ.push_back('{size: SIZE_W'(512), pad: (i == ns - 1) ? PAD_W'(pad) : '0,
                        last: (i == ns - 1), tail: 1'b1});
    for (int i = 0; i < len; i++) begin
      logic b;
      b = 1'($urandom);
      srcQ.push_back(b); bitQ.push_back(b); padQ.push_back(1'b0);
    end
    for (int i = 0; i < pad; i++) begin
      bitQ.push_back(1'b0); padQ.push_back(1'b1);
    end
    @(negedge clk);
    lenValid = 1'b1;
    lenBits  = LEN_W'(len);
    #1.5;
    check(lenReady, "R8", "idle before frame", lenReady, 1);
    @(negedge clk);
    lenBits = LEN_W'(7);          // intruding length while busy
    #1.5;
    check(!lenReady, "R8", "busy after accept", lenReady, 0);
    for (int i = 0; i < 3; i++) begin
      sampleWait();
      check(!lenReady && !lenError, "R8", "length accepted while busy",
            {lenReady, lenError}, 0);
    end
    lenValid = 1'b0;
    do sampleWait(); while (descQ.size() != 0 || bitQ.size() != 0 || !lenReady);
    check(srcQ.size() == 0, "R6", "payload bits left unconsumed", srcQ.size(), 0);
  endtask

  task automatic rejectZero();
    @(negedge clk);
    lenValid = 1'b1;
    lenBits  = '0;
    @(negedge clk);
    lenValid = 1'b0;
    #1.5;
    check(lenError, "R7", "error pulse on zero length", lenError, 1);
    check(lenReady && !descValid && !bitOutValid, "R7", "zero length started a frame",
          {lenReady, descValid, bitOutValid}, 3'b100);
    sampleWait();
    check(!lenError, "R7", "error pulse length", lenError, 0);
    check(lenReady && !descValid && !bitOutValid, "R7", "state after zero length",
          {lenReady, descValid, bitOutValid}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1.5;
    check(lenReady, "R1", "lenReady after reset", lenReady, 1);
    check(!descValid, "R1", "descValid after reset", descValid, 0);
    check(!bitOutValid, "R1", "bitOutValid after reset", bitOutValid, 0);
    check(!lenError, "R1", "lenError after reset", lenError, 0);

    rejectZero();
    runFrame(1, 0, 0, 0);        // K=1, one tail block, pad 511
    runFrame(512, 0, 0, 0);      // exact fit, no pad
    runFrame(513, 0, 0, 0);      // K=2, two tail blocks
    runFrame(2048, 0, 0, 0);     // K=4, four tail blocks, no long block
    runFrame(2560, 1, 1, 1);     // K=5, one long + one tail, random pacing
    rejectZero();
    runFrame(4096, 0, 0, 0);     // K=8, one long + four tail
    runFrame(4097, 0, 1, 0);     // K=9, two long + one tail
    runFrame(300, 2, 0, 0);      // last descriptor and last bit on one edge
    runFrame(10000, 0, 0, 0);    // K=20, four long + four tail, pad 240
    runFrame(1000, 1, 1, 1);     // follow-up frame after the shared-edge case
    check(descQ.size() == 0 && bitQ.size() == 0, "R6", "scoreboard drained",
          descQ.size() + bitQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule